// File: doc/BRIEF.md
# Cycle-Stealing DMA Controller

This block is a single-channel DMA engine that sits beside the processor on a shared system bus. Software writes a device address, a memory start address, a word count and a direction into four configuration registers, and then sets a start bit. From then on the engine moves the block without the processor. For each word it raises a bus request and waits for the arbiter's grant. It performs exactly one bus access in the granted cycle and then lets go of the bus for at least one cycle, so the processor only loses single cycles.

The device sits directly on the engine, so each word needs only one bus access. In device-to-memory mode the engine strobes a read at the device and a write at memory in the same cycle, and the device's data goes straight onto the bus write data. In memory-to-device mode it strobes a bus read and a device write, and the bus read data goes straight to the device. After every word the memory address steps up by one and the remaining count steps down by one. When the count reaches zero the engine raises a completion interrupt, which stays high until software acknowledges it.

The controller is a three-state machine: IDLE (waiting for a start), ASK (request raised; the word moves in the first cycle grant is seen) and GAP (one-cycle release after a word). The transitions are:
- IDLE→ASK on a start with a nonzero count.
- IDLE→IDLE on a start with a zero count, which raises the interrupt at once.
- ASK→ASK while grant is low.
- ASK→GAP on a granted word that leaves words pending.
- ASK→IDLE on the granted last word.
- GAP→ASK always.

Top module: `cs_dma`

## Requirements
- R1: After reset, busy, direction and interrupt read back as 0, all four registers read 0, `bus_req` is low and no strobe is active.
- R2: A write to register select 0 with bit 0 set, made while idle with a nonzero count, raises `bus_req` in the next cycle. Reading select 0 then returns busy (bit 0) as 1.
- R3: `bus_addr`, `dev_addr` and all four strobes are zero unless `bus_req` and `bus_gnt` are both high. The word moves in that cycle.
- R4: After every word `bus_req` is low for exactly one cycle before the next request.
- R5: With direction 0 (device to memory), a word asserts `dev_rd` and `bus_we` with `bus_wdata` equal to `dev_rdata`. `bus_addr` is the current memory address and `dev_addr` the programmed device address.
- R6: With direction 1 (memory to device), a word asserts `bus_rd` and `dev_wr` with `dev_wdata` equal to `bus_rdata`.
- R7: Each word adds 1 to the memory address, wrapping modulo 2^AW, and subtracts 1 from the count (select 2 and select 3 read back live values). The device address does not change.
- R8: The word that brings the count to zero sets `irq` and clears busy. `irq` stays set until a select-0 write with bit 2 set, which clears it. If the interrupt is set and cleared in the same cycle, the set wins.
- R9: A start with a count of 0 sets `irq` in the next cycle and never raises `bus_req`.
- R10: While busy, writes to selects 1, 2, 3 and to the direction bit, and further starts, are ignored. A select-0 write made while idle loads the direction from bit 1.
- R11: `cfg_rdata` shows the register picked by `cfg_sel`: 0 status {irq, direction, busy} in bits 2..0, 1 device address, 2 memory address, 3 count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Read data of the selected register |
| bus_req | output | 1 | Bus request to arbiter |
| bus_gnt | input | 1 | Bus grant from arbiter |
| bus_addr | output | AW | Memory address during a word |
| bus_we | output | 1 | Memory write strobe |
| bus_rd | output | 1 | Memory read strobe |
| bus_wdata | output | DW | Memory write data |
| bus_rdata | input | DW | Memory read data |
| dev_addr | output | DEVW | Device address during a word |
| dev_rd | output | 1 | Device read strobe |
| dev_wr | output | 1 | Device write strobe |
| dev_rdata | input | DW | Data from device |
| dev_wdata | output | DW | Data to device |
| irq | output | 1 | Completion interrupt |

## Verification
The bench keeps the grant low for long stretches while a request is pending. A design that moved data or drove an address without grant, or dropped its request, would show a strobe or a missing request in those cycles. A memory start two words below the top of the address space checks the wrap. A design that saturated or carried into other bits would read back a wrong address. Register writes and starts are issued while the engine is stalled mid-block, where a leaking write would corrupt the live address or count. A zero-count start checks that the interrupt arrives without a stray bus request, and that the engine does not count down through the whole range.

// File: rtl/cs_dma_pkg.sv
`timescale 1ns/1ps
package cs_dma_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ASK  = 2'd1,
        ST_GAP  = 2'd2
    } dma_state_e;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_DEV  = 2'd1;
    localparam logic [1:0] SEL_MEM  = 2'd2;
    localparam logic [1:0] SEL_CNT  = 2'd3;

    localparam int BIT_GO  = 0;
    localparam int BIT_DIR = 1;
    localparam int BIT_ACK = 2;
endpackage

// File: rtl/cs_dma_regs.sv
`timescale 1ns/1ps
module cs_dma_regs
    import cs_dma_pkg::*;
#(
    parameter int DW   = 16,
    parameter int AW   = 16,
    parameter int CW   = 16,
    parameter int DEVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_sel,
    input  logic [DW-1:0]   cfg_wdata,
    input  logic            busy,
    input  logic            step,
    input  logic            done_set,
    output logic            go,
    output logic [DEVW-1:0] dev_addr_q,
    output logic [AW-1:0]   mem_addr_q,
    output logic [CW-1:0]   count_q,
    output logic            dir_q,
    output logic            irq_q,
    output logic [DW-1:0]   cfg_rdata
);
    logic idle_wr;
    logic ctrl_wr;
    logic ack_wr;

    assign idle_wr = cfg_we && !busy;
    assign ctrl_wr = cfg_we && (cfg_sel == SEL_CTRL);
    assign ack_wr  = ctrl_wr && cfg_wdata[BIT_ACK];
    assign go      = idle_wr && (cfg_sel == SEL_CTRL) && cfg_wdata[BIT_GO];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_addr_q <= '0;
            mem_addr_q <= '0;
            count_q    <= '0;
            dir_q      <= 1'b0;
            irq_q      <= 1'b0;
        end else begin
            if (idle_wr && cfg_sel == SEL_DEV)
                dev_addr_q <= cfg_wdata[DEVW-1:0];
            if (step)
                mem_addr_q <= mem_addr_q + AW'(1);
            else if (idle_wr && cfg_sel == SEL_MEM)
                mem_addr_q <= cfg_wdata[AW-1:0];
            if (step)
                count_q <= count_q - CW'(1);
            else if (idle_wr && cfg_sel == SEL_CNT)
                count_q <= cfg_wdata[CW-1:0];
            if (idle_wr && cfg_sel == SEL_CTRL)
                dir_q <= cfg_wdata[BIT_DIR];
            if (done_set)
                irq_q <= 1'b1;
            else if (ack_wr)
                irq_q <= 1'b0;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_sel)
            SEL_CTRL: begin
                cfg_rdata[BIT_GO]  = busy;
                cfg_rdata[BIT_DIR] = dir_q;
                cfg_rdata[BIT_ACK] = irq_q;
            end
            SEL_DEV:  cfg_rdata[DEVW-1:0] = dev_addr_q;
            SEL_MEM:  cfg_rdata[AW-1:0]   = mem_addr_q;
            SEL_CNT:  cfg_rdata[CW-1:0]   = count_q;
            default:  cfg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cs_dma_fsm.sv
`timescale 1ns/1ps
module cs_dma_fsm
    import cs_dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic count_zero,
    input  logic last_word,
    input  logic bus_gnt,
    output logic busy,
    output logic bus_req,
    output logic xfer,
    output logic done_set
);
    dma_state_e st, nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: if (go && !count_zero) nxt = ST_ASK;
            ST_ASK:  if (bus_gnt) nxt = last_word ? ST_IDLE : ST_GAP;
            ST_GAP:  nxt = ST_ASK;
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        busy     = (st != ST_IDLE);
        bus_req  = (st == ST_ASK);
        xfer     = (st == ST_ASK) && bus_gnt;
        done_set = ((st == ST_IDLE) && go && count_zero) || (xfer && last_word);
    end
endmodule

// File: rtl/cs_dma.sv
`timescale 1ns/1ps
module cs_dma #(
    parameter int DW   = 16,
    parameter int AW   = 16,
    parameter int CW   = 16,
    parameter int DEVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_sel,
    input  logic [DW-1:0]   cfg_wdata,
    output logic [DW-1:0]   cfg_rdata,
    output logic            bus_req,
    input  logic            bus_gnt,
    output logic [AW-1:0]   bus_addr,
    output logic            bus_we,
    output logic            bus_rd,
    output logic [DW-1:0]   bus_wdata,
    input  logic [DW-1:0]   bus_rdata,
    output logic [DEVW-1:0] dev_addr,
    output logic            dev_rd,
    output logic            dev_wr,
    input  logic [DW-1:0]   dev_rdata,
    output logic [DW-1:0]   dev_wdata,
    output logic            irq
);
    logic            go, busy, xfer, done_set;
    logic [DEVW-1:0] dev_addr_q;
    logic [AW-1:0]   mem_addr_q;
    logic [CW-1:0]   count_q;
    logic            dir_q;
    logic            to_mem, to_dev;

    cs_dma_regs #(.DW(DW), .AW(AW), .CW(CW), .DEVW(DEVW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .busy       (busy),
        .step       (xfer),
        .done_set   (done_set),
        .go         (go),
        .dev_addr_q (dev_addr_q),
        .mem_addr_q (mem_addr_q),
        .count_q    (count_q),
        .dir_q      (dir_q),
        .irq_q      (irq),
        .cfg_rdata  (cfg_rdata)
    );

    cs_dma_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .count_zero (count_q == '0),
        .last_word  (count_q == CW'(1)),
        .bus_gnt    (bus_gnt),
        .busy       (busy),
        .bus_req    (bus_req),
        .xfer       (xfer),
        .done_set   (done_set)
    );

    assign to_mem = xfer && !dir_q;
    assign to_dev = xfer &&  dir_q;

    always_comb begin
        bus_addr  = xfer   ? mem_addr_q : '0;
        dev_addr  = xfer   ? dev_addr_q : '0;
        bus_we    = to_mem;
        dev_rd    = to_mem;
        bus_rd    = to_dev;
        dev_wr    = to_dev;
        bus_wdata = to_mem ? dev_rdata : '0;
        dev_wdata = to_dev ? bus_rdata : '0;
    end
endmodule

// File: rtl/cs_dma_chk.sv
`timescale 1ns/1ps
module cs_dma_chk #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [1:0]    cfg_sel,
    input logic          ctl_go,
    input logic          ctl_ack,
    input logic          busy,
    input logic [CW-1:0] count_q,
    input logic          bus_req,
    input logic          bus_gnt,
    input logic          bus_we,
    input logic          bus_rd,
    input logic          dev_rd,
    input logic          dev_wr,
    input logic          irq
);
    logic start_wr;
    logic word;
    assign start_wr = cfg_we && (cfg_sel == 2'd0) && ctl_go && !busy;
    assign word     = bus_we || bus_rd;

    a_r2_start_requests: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && count_q != '0) |=> bus_req);

    a_r3_no_strobe_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && bus_gnt) |-> !(bus_we || bus_rd || dev_rd || dev_wr));

    a_r4_release_after_word: assert property (@(posedge clk) disable iff (!rst_n)
        word |=> !bus_req);

    a_r5_d2m_pairing: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rd |-> (bus_we && !bus_rd && !dev_wr));

    a_r6_m2d_pairing: assert property (@(posedge clk) disable iff (!rst_n)
        dev_wr |-> (bus_rd && !bus_we && !dev_rd));

    a_r7_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        word |=> (count_q == $past(count_q) - CW'(1)));

    a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(cfg_we && cfg_sel == 2'd0 && ctl_ack)) |=> irq);

    a_r9_zero_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && count_q == '0) |=> (irq && !bus_req));
endmodule

bind cs_dma cs_dma_chk #(.CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .cfg_sel (cfg_sel),
    .ctl_go  (cfg_wdata[0]),
    .ctl_ack (cfg_wdata[2]),
    .busy    (busy),
    .count_q (count_q),
    .bus_req (bus_req),
    .bus_gnt (bus_gnt),
    .bus_we  (bus_we),
    .bus_rd  (bus_rd),
    .dev_rd  (dev_rd),
    .dev_wr  (dev_wr),
    .irq     (irq)
);

// File: tb/tb_cs_dma.sv
`timescale 1ns/1ps
module tb_cs_dma;
    localparam int DW = 16, AW = 16, CW = 16, DEVW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [DW-1:0] cfg_wdata = '0;
    logic [DW-1:0] cfg_rdata;
    logic bus_req, bus_gnt, bus_we, bus_rd, dev_rd, dev_wr, irq;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata, dev_rdata, dev_wdata;
    logic [DEVW-1:0] dev_addr;

    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // arbiter: 0 random, 1 always, 2 never
    int gnt_mode = 1;
    logic [7:0] lfsr = 8'hA5;
    logic allow = 1'b0;
    assign bus_gnt = bus_req && allow;
    always @(negedge clk) begin
        lfsr  <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        allow <= (gnt_mode == 1) ? 1'b1 : (gnt_mode == 2) ? 1'b0 : lfsr[0];
    end

    // memory and device models
    logic [DW-1:0] mem [0:255];
    logic [DW-1:0] src_val = 16'h1000;
    logic [DW-1:0] sink_q [$];
    assign bus_rdata = mem[bus_addr[7:0]];
    assign dev_rdata = src_val;
    always @(posedge clk) begin
        if (bus_we) mem[bus_addr[7:0]] <= bus_wdata;
        if (dev_rd) src_val <= src_val + 16'h0101;
        if (dev_wr) sink_q.push_back(dev_wdata);
    end

    cs_dma #(.DW(DW), .AW(AW), .CW(CW), .DEVW(DEVW)) dut (.*);

    // behavioural reference model
    int m_phase;              // 0 idle, 1 asking, 2 gap
    logic [DEVW-1:0] m_dev;
    logic [AW-1:0] m_mem;
    logic [CW-1:0] m_cnt;
    logic m_dir, m_irq;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase <= 0; m_dev <= '0; m_mem <= '0; m_cnt <= '0;
            m_dir <= 1'b0; m_irq <= 1'b0;
        end else begin
            if (cfg_we && cfg_sel == 2'd0 && cfg_wdata[2]) m_irq <= 1'b0;
            if (m_phase == 0) begin
                if (cfg_we) begin
                    case (cfg_sel)
                        2'd0: m_dir <= cfg_wdata[1];
                        2'd1: m_dev <= cfg_wdata[DEVW-1:0];
                        2'd2: m_mem <= cfg_wdata;
                        default: m_cnt <= cfg_wdata;
                    endcase
                    if (cfg_sel == 2'd0 && cfg_wdata[0]) begin
                        if (m_cnt == 0) m_irq <= 1'b1;
                        else m_phase <= 1;
                    end
                end
            end else if (m_phase == 2) begin
                m_phase <= 1;
            end else if (allow) begin
                m_mem <= m_mem + 1'b1;
                m_cnt <= m_cnt - 1'b1;
                if (m_cnt == 1) begin m_phase <= 0; m_irq <= 1'b1; end
                else m_phase <= 2;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] exp_rdata();
        case (cfg_sel)
            2'd0: return {13'd0, m_irq, m_dir, m_phase != 0};
            2'd1: return {8'd0, m_dev};
            2'd2: return m_mem;
            default: return m_cnt;
        endcase
    endfunction

    // per-cycle comparison, 1 ns before the next rising edge
    always @(posedge clk) begin
        #4;
        if (rst_n) begin
            logic act;
            act = (m_phase == 1) && allow;
            chk("R2/R4 bus_req", bus_req, m_phase == 1);
            chk("R3 bus_addr", bus_addr, act ? m_mem : 16'h0);
            chk("R3 dev_addr", dev_addr, act ? m_dev : 8'h0);
            chk("R5 dev_rd", dev_rd, act && !m_dir);
            chk("R5 bus_we", bus_we, act && !m_dir);
            chk("R6 bus_rd", bus_rd, act && m_dir);
            chk("R6 dev_wr", dev_wr, act && m_dir);
            chk("R5 bus_wdata", bus_wdata, (act && !m_dir) ? src_val : 16'h0);
            chk("R6 dev_wdata", dev_wdata, (act && m_dir) ? mem[m_mem[7:0]] : 16'h0);
            chk("R8 irq", irq, m_irq);
            chk("R11 cfg_rdata", cfg_rdata, exp_rdata());
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [DW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] sel, input logic [DW-1:0] exp);
        @(negedge clk);
        cfg_sel = sel;
        #1 chk(tag, cfg_rdata, exp);
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 2000 && !irq; i++) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 3 + 16'h0700);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1;
        chk("R1 bus_req", bus_req, 0);
        chk("R1 irq", irq, 0);
        chk("R1 strobes", {bus_we, bus_rd, dev_rd, dev_wr}, 0);
        for (int s = 0; s < 4; s++) rd_chk("R1 reg", 2'(s), 16'h0);

        // device to memory, random grant
        gnt_mode = 0;
        wr(2'd1, 16'h005A);
        wr(2'd2, 16'h0010);
        wr(2'd3, 16'd4);
        begin
            logic [DW-1:0] s0;
            s0 = src_val;
            wr(2'd0, 16'h0001);
            #1 chk("R2 busy after start", cfg_rdata[0], 1);
            wait_irq();
            for (int i = 0; i < 4; i++)
                chk("R5 memory word", mem[8'h10 + i], s0 + 16'(i) * 16'h0101);
        end
        rd_chk("R7 mem address end", 2'd2, 16'h0014);
        rd_chk("R7 count end", 2'd3, 16'h0000);
        rd_chk("R7 device address kept", 2'd1, 16'h005A);
        rd_chk("R8 status irq set, idle", 2'd0, 16'h0004);
        repeat (3) @(negedge clk);
        #1 chk("R8 irq held", irq, 1);
        wr(2'd0, 16'h0004);
        #1 chk("R8 irq cleared", irq, 0);

        // memory to device across the address wrap
        gnt_mode = 1;
        sink_q.delete();
        wr(2'd1, 16'h0033);
        wr(2'd2, 16'hFFFE);
        wr(2'd3, 16'd3);
        wr(2'd0, 16'h0003);
        wait_irq();
        chk("R6 sink count", sink_q.size(), 3);
        if (sink_q.size() == 3) begin
            chk("R6 sink word0", sink_q[0], mem[8'hFE]);
            chk("R6 sink word1", sink_q[1], mem[8'hFF]);
            chk("R6 sink word2", sink_q[2], mem[8'h00]);
        end
        rd_chk("R7 wrap address", 2'd2, 16'h0001);
        wr(2'd0, 16'h0004);

        // writes while busy, grant withheld
        gnt_mode = 2;
        wr(2'd2, 16'h0040);
        wr(2'd3, 16'd6);
        wr(2'd0, 16'h0001);
        repeat (10) @(negedge clk);
        #1 chk("R3 no strobe while stalled", {bus_we, bus_rd, dev_rd, dev_wr}, 0);
        chk("R2 request held", bus_req, 1);
        wr(2'd2, 16'h0099);
        wr(2'd3, 16'd7);
        wr(2'd1, 16'h00EE);
        wr(2'd0, 16'h0003);
        rd_chk("R10 mem addr locked", 2'd2, 16'h0040);
        rd_chk("R10 count locked", 2'd3, 16'd6);
        rd_chk("R10 dev addr locked", 2'd1, 16'h0033);
        rd_chk("R10 dir locked", 2'd0, 16'h0001);
        gnt_mode = 0;
        wait_irq();
        rd_chk("R7 after stalled run", 2'd2, 16'h0046);
        wr(2'd0, 16'h0004);

        // zero count start
        wr(2'd3, 16'd0);
        wr(2'd0, 16'h0001);
        #1 chk("R9 irq at once", irq, 1);
        chk("R9 no request", bus_req, 0);
        repeat (3) @(negedge clk);
        #1 chk("R9 still no request", bus_req, 0);
        rd_chk("R9 count stays zero", 2'd3, 16'd0);
        wr(2'd0, 16'h0004);
        #1 chk("R8 cleared after zero start", irq, 0);

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule